// File: doc/BRIEF.md
# Parity Transceiver with Sticky Error Flag

This block sits between two eight-bit buses, called the A side and the B side, and passes data across in either direction under two active-low enables. A ninth line carries an odd-parity bit. When data goes toward B the block drives that line with a freshly generated parity bit. When data goes toward A the line is an input, and the block checks the received byte together with it. The pads are modelled as separate value, drive-enable and input signals per side. The error pin is modelled as a pull-low enable, in the style of an open-collector output.

A one-bit flag register records a parity failure on the rising edge of `clk`. Once set it stays set until the asynchronous active-low `clear_n` releases it, so software or a test controller can let traffic run and inspect the flag later. When both enables are asserted, a diagnostic mode drives data toward B with the parity bit deliberately inverted. In that mode the flag is loaded from the parity of the A byte, which lets the error path be exercised on purpose.

Top module: `parity_xcvr`

## Requirements
- R1: With `b_oe_n`=0 and `a_oe_n`=1, `b_out` equals `a_in`, `b_drv` and `par_drv` are 1, `a_drv` is 0, and `par_out` makes the nine bits {`b_out`,`par_out`} hold an odd number of ones.
- R2: With `a_oe_n`=0 and `b_oe_n`=1, `a_out` equals `b_in`, `a_drv` is 1, and `b_drv` and `par_drv` are 0.
- R3: With both enables at 1, `a_drv`, `b_drv` and `par_drv` are all 0.
- R4: With both enables at 0, `b_out` equals `a_in`, and `a_drv`, `b_drv` and `par_drv` are all 1. `a_out` equals `b_in`, and `par_out` is the inverse of the R1 parity bit, so the nine driven bits hold an even count.
- R5: While `b_oe_n`=1, a rising `clk` edge with `clear_n`=1 sets the flag (`err_pull`=1) when `b_in` and `par_in` together hold an even number of ones.
- R6: Once set, the flag stays set on every later edge until `clear_n` goes low, whatever the inputs are.
- R7: `clear_n`=0 clears the flag at once, without waiting for a clock edge, and keeps it clear across any edges that occur while it is low.
- R8: In the mode of R4, a rising edge sets the flag when `a_in` holds an even number of ones and leaves a clear flag clear when the count is odd.
- R9: In the mode of R1, a rising edge never sets a clear flag.
- R10: After `clear_n` is first asserted, `err_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Flag sampling clock, rising edge |
| clear_n | input | 1 | Asynchronous active-low flag clear |
| a_oe_n | input | 1 | Active-low enable for driving the A side |
| b_oe_n | input | 1 | Active-low enable for driving the B side and the parity line |
| a_in | input | W | Value seen on the A pads |
| a_out | output | W | Value to drive on the A pads |
| a_drv | output | 1 | Drive enable for the A pads |
| b_in | input | W | Value seen on the B pads |
| b_out | output | W | Value to drive on the B pads |
| b_drv | output | 1 | Drive enable for the B pads |
| par_in | input | 1 | Value seen on the parity pad |
| par_out | output | 1 | Value to drive on the parity pad |
| par_drv | output | 1 | Drive enable for the parity pad |
| err_pull | output | 1 | 1 pulls the error pin low (flag set); 0 leaves it floating |

## Verification
The bench sweeps all four enable combinations over bytes with zero, one, seven and eight ones and over both parity-line values. It clears the flag between samples so that each error decision is seen on its own. Three kinds of bug are targeted: a checker that inverts the parity sense, which would flag good B traffic and pass bad traffic, and a generator that emits even parity, which would show up on the driven nine bits. The third is a diagnostic mode that feeds the inverted bit into the checker, which would flag every byte instead of only the even ones. A separate sequence follows a failure with good traffic, to catch a flag that reloads instead of sticking. Another holds clear low across edges with bad input, to catch a clear that is only sampled synchronously.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;

    typedef enum logic [1:0] {
        XM_OFF  = 2'd0,
        XM_A2B  = 2'd1,
        XM_B2A  = 2'd2,
        XM_DIAG = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic flag;
    } flag_state_t;

endpackage

// File: rtl/parity_xcvr_mode.sv
module parity_xcvr_mode
    import parity_xcvr_pkg::*;
(
    input  logic       a_oe_n,
    input  logic       b_oe_n,
    output xfer_mode_e mode
);

    always_comb begin
        case ({a_oe_n, b_oe_n})
            2'b10:   mode = XM_A2B;
            2'b01:   mode = XM_B2A;
            2'b00:   mode = XM_DIAG;
            default: mode = XM_OFF;
        endcase
    end

endmodule

// File: rtl/parity_xcvr_tree.sv
module parity_xcvr_tree #(
    parameter int N = 9
) (
    input  logic [N-1:0] bits,
    output logic         odd
);

    logic [N:0] acc;

    assign acc[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_xor
        assign acc[i+1] = acc[i] ^ bits[i];
    end

    assign odd = acc[N];

endmodule

// File: rtl/parity_xcvr_flag.sv
module parity_xcvr_flag
    import parity_xcvr_pkg::*;
(
    input  logic clk,
    input  logic clear_n,
    input  logic sample_bad,
    output logic flag
);

    flag_state_t st_d;
    flag_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = st_q.flag | sample_bad;
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!clear_n)
        st_q.flag |=> st_q.flag);

    // R5
    bad_sets_chk: assert property (@(posedge clk) disable iff (!clear_n)
        sample_bad |=> st_q.flag);

    // R7
    clear_wins_chk: assert property (@(posedge clk)
        !clear_n |-> !st_q.flag);

endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
    import parity_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         a_oe_n,
    input  logic         b_oe_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    input  logic         par_in,
    output logic         par_out,
    output logic         par_drv,
    output logic         err_pull
);

    localparam int CHK_W = W + 1;

    xfer_mode_e     mode;
    logic           a_odd;
    logic [W-1:0]   chk_data;
    logic           chk_ninth;
    logic           chk_odd;
    logic           sample_bad;

    parity_xcvr_mode u_mode (
        .a_oe_n (a_oe_n),
        .b_oe_n (b_oe_n),
        .mode   (mode)
    );

    parity_xcvr_tree #(.N(W)) u_gen (
        .bits (a_in),
        .odd  (a_odd)
    );

    assign a_out   = b_in;
    assign b_out   = a_in;
    assign a_drv   = !a_oe_n;
    assign b_drv   = !b_oe_n;
    assign par_drv = !b_oe_n;
    // generated bit is ~a_odd; diagnostic mode drives it inverted
    assign par_out = (mode == XM_DIAG) ? a_odd : !a_odd;

    assign chk_data = b_oe_n ? b_in : a_in;

    always_comb begin
        case (mode)
            XM_A2B:  chk_ninth = par_out;
            XM_DIAG: chk_ninth = 1'b0;
            default: chk_ninth = par_in;
        endcase
    end

    parity_xcvr_tree #(.N(CHK_W)) u_chk (
        .bits ({chk_ninth, chk_data}),
        .odd  (chk_odd)
    );

    assign sample_bad = !chk_odd;

    parity_xcvr_flag u_flag (
        .clk        (clk),
        .clear_n    (clear_n),
        .sample_bad (sample_bad),
        .flag       (err_pull)
    );

    // R1
    a2b_odd_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (a_oe_n && !b_oe_n) |-> ((^{b_out, par_out}) && b_drv && par_drv && !a_drv));

    // R4
    diag_even_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (!a_oe_n && !b_oe_n) |-> (!(^{b_out, par_out}) && a_drv && b_drv));

    // R3
    all_off_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (a_oe_n && b_oe_n) |-> (!a_drv && !b_drv && !par_drv));

    // R9
    a2b_no_err_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (a_oe_n && !b_oe_n && !err_pull) |=> !err_pull);

endmodule

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;

    localparam int  W          = 8;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         clear_n = 1'b0;
    logic         a_oe_n = 1'b1;
    logic         b_oe_n = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         par_in = 1'b0;
    logic [W-1:0] a_out, b_out;
    logic         a_drv, b_drv, par_out, par_drv, err_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_xcvr #(.W(W)) uut (
        .clk      (clk),
        .clear_n  (clear_n),
        .a_oe_n   (a_oe_n),
        .b_oe_n   (b_oe_n),
        .a_in     (a_in),
        .a_out    (a_out),
        .a_drv    (a_drv),
        .b_in     (b_in),
        .b_out    (b_out),
        .b_drv    (b_drv),
        .par_in   (par_in),
        .par_out  (par_out),
        .par_drv  (par_drv),
        .err_pull (err_pull)
    );

    typedef struct {
        logic [W-1:0] a_out;
        logic [W-1:0] b_out;
        logic         a_drv;
        logic         b_drv;
        logic         par_drv;
        logic         par_out;
        logic         err;
        string        dreq;
        string        ereq;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;

    logic m_err      = 1'b0;
    logic prev_clear = 1'b0;
    logic prev_bad   = 1'b0;
    int   prev_mode  = 3;
    bit   first      = 1'b1;

    function automatic logic odd_ones(input logic [W-1:0] v);
        int c = 0;
        for (int i = 0; i < W; i++) c += int'(v[i]);
        return (c % 2) == 1;
    endfunction

    // mode codes: 0 both low, 1 B to A, 2 A to B, 3 all off
    task automatic step(input logic aoe, input logic boe, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic p, input logic clr);
        exp_t e;
        int   md;
        bit   was_set;
        logic bad;
        @(posedge clk);
        #1;
        was_set = m_err;
        m_err = prev_clear ? (m_err | prev_bad) : 1'b0;
        if (!clr) m_err = 1'b0;
        if (first) e.ereq = "R10";
        else if (!clr || !prev_clear) e.ereq = "R7";
        else if (was_set) e.ereq = "R6";
        else if (prev_mode == 2) e.ereq = "R9";
        else if (prev_mode == 0) e.ereq = "R8";
        else e.ereq = "R5";
        first = 1'b0;
        a_oe_n = aoe; b_oe_n = boe; a_in = a; b_in = b; par_in = p; clear_n = clr;
        md = {aoe, boe};
        e.a_out   = b;
        e.b_out   = a;
        e.a_drv   = !aoe;
        e.b_drv   = !boe;
        e.par_drv = !boe;
        e.par_out = (md == 0) ? odd_ones(a) : !odd_ones(a);
        e.err     = m_err;
        case (md)
            0: e.dreq = "R4";
            1: e.dreq = "R2";
            2: e.dreq = "R1";
            default: e.dreq = "R3";
        endcase
        if (md == 2) bad = 1'b0;
        else if (md == 0) bad = !odd_ones(a);
        else bad = !(odd_ones(b) ^ p);
        sb.push_back(e);
        prev_clear = clr;
        prev_bad   = bad;
        prev_mode  = md;
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            bit   ok;
            e = sb.pop_front();
            ok = (a_drv == e.a_drv) && (b_drv == e.b_drv) && (par_drv == e.par_drv)
                 && (!e.a_drv || a_out == e.a_out)
                 && (!e.b_drv || b_out == e.b_out)
                 && (!e.par_drv || par_out == e.par_out);
            checks++;
            if (!ok) begin
                fails++;
                $display("FAIL %s drive: got a=%h/%b b=%h/%b p=%b/%b exp a=%h/%b b=%h/%b p=%b/%b",
                         e.dreq, a_out, a_drv, b_out, b_drv, par_out, par_drv,
                         e.a_out, e.a_drv, e.b_out, e.b_drv, e.par_out, e.par_drv);
            end
            checks++;
            if (err_pull !== e.err) begin
                fails++;
                $display("FAIL %s flag: got %b exp %b", e.ereq, err_pull, e.err);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        logic [W-1:0] pats [6];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h01;
        pats[3] = 8'h80; pats[4] = 8'hA5; pats[5] = 8'h7F;

        // R10: reset state
        step(1'b1, 1'b1, '0, '0, 1'b0, 1'b0);
        step(1'b1, 1'b1, '0, '0, 1'b0, 1'b0);

        // sweep modes R1 R2 R3 R4, each sample followed by a clear (R7)
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 6; k++) begin
                for (int p = 0; p < 2; p++) begin
                    step(m[1], m[0], pats[k], pats[5-k], p[0], 1'b1);
                    step(m[1], m[0], pats[k], pats[5-k], p[0], 1'b1);
                    step(m[1], m[0], pats[k], pats[5-k], p[0], 1'b0);
                end
            end
        end

        // R6: failure in B to A, then good traffic in every mode
        step(1'b0, 1'b1, '0, 8'h03, 1'b0, 1'b1);
        step(1'b0, 1'b1, '0, 8'h03, 1'b1, 1'b1);
        step(1'b1, 1'b0, 8'h01, '0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 8'h07, '0, 1'b0, 1'b1);
        step(1'b1, 1'b1, '0, 8'h01, 1'b0, 1'b1);
        step(1'b1, 1'b1, '0, 8'h01, 1'b0, 1'b1);

        // R7: clear held low across edges with bad inputs, then released
        step(1'b0, 1'b1, '0, 8'h00, 1'b0, 1'b0);
        step(1'b0, 1'b1, '0, 8'h00, 1'b0, 1'b0);
        step(1'b0, 1'b1, '0, 8'h00, 1'b1, 1'b1);
        step(1'b0, 1'b1, '0, 8'h00, 1'b1, 1'b1);

        // R9: long run of A to B traffic never flags
        step(1'b1, 1'b1, '0, '0, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, pats[k], '0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 8'h00, '0, 1'b0, 1'b1);

        @(posedge clk);
        @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule